// File: doc/BRIEF.md
# Stipple and Block-Copy Raster Engine

This block speeds up 2D drawing on a frame buffer that holds one byte per pixel. A host issues single 32-bit writes into one of three address windows. A write to the control window loads the foreground colour. A write to the stipple window takes a 32-bit pattern and paints the foreground colour into the pixels whose pattern bits are set, starting with the most significant bit. A write to the blit window either fills a run of 1 to 32 pixels with the foreground colour, or copies such a run from a source pixel address.

In both drawing windows the destination pixel comes from the bus address, not from the data. The engine drives a single-port frame memory, which has a read latency of one cycle, with at most one access per clock. It holds back new requests until the current command is done. When a command finishes it emits a one-cycle report of the pixel range it covered, so that a display path can refresh only that range.

Top module: `raster_engine`

## Requirements
- R1: A write uses its bus address as follows. Bits [BUS_AW-1:BUS_AW-2] select the window: 00 is control, 01 is stipple, 10 is blit and 11 is unused. Bits [PIX_AW+2:3] give the destination pixel. Bit 2 is ignored.
- R2: A stipple command paints the colour into pixel dest+i when pattern bit 31-i is set, for i = 0 to 31. Pixels whose pattern bit is clear keep their old value.
- R3: A stipple command reports base = dest and length = 32 when it finishes, whatever the pattern, even if the pattern is all zeros.
- R4: In a blit command, data bits [23:0] hold the source and bits [28:24] hold the run length minus 1. A source of 0xFFFFFF fills the run with the colour. Bits [31:29] are ignored.
- R5: Any other source copies the run in ascending order: pixel dest+i receives the old content of pixel src+i, where src is the low PIX_AW bits of the field. Each pixel takes one read cycle followed by one write cycle, so a run that overlaps forward smears the first source pixel along the run.
- R6: A blit command reports base = dest and length = the run length when it finishes.
- R7: A read from any window has no effect. One cycle after the read is accepted, rd_valid is high and rd_data is zero.
- R8: A write is ignored if its byte enables are not 4'b1111, if address bits [1:0] are not zero, or if it targets the unused window. An ignored write changes no memory, the colour and the busy state, and produces no report.
- R9: The engine makes at most one memory access per clock. A fill of length n takes n accesses and a copy of length n takes 2n. While busy is high, req_ready is low.
- R10: A control-window write loads data bits [7:0] as the colour.
- R11: After reset: busy is low, req_ready is high, there is no memory access and no report, and the colour is 0.
- R12: Pixel addresses wrap modulo 2^PIX_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables |
| req_addr | input | BUS_AW | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data (always zero) |
| busy | output | 1 | Command in progress |
| mem_en | output | 1 | Frame memory access |
| mem_we | output | 1 | Frame memory write |
| mem_addr | output | PIX_AW | Frame memory pixel address |
| mem_wdata | output | 8 | Frame memory write byte |
| mem_rdata | input | 8 | Frame memory read byte, valid one cycle after a read |
| dirty_valid | output | 1 | Modified-range report strobe |
| dirty_base | output | PIX_AW | First pixel of the range |
| dirty_len | output | 6 | Number of pixels in the range (1 to 32) |

## Verification
Almost every fault in the sequencer becomes visible as memory content on the next write cycle. A wrong index shows up as a shifted pixel. A pattern shifted the wrong way paints mirrored pixels. A misrouted read lands stale data in the copy destination. A wrong colour register shows up in the first pixel of the next fill or stipple. A wrong run counter changes both the number of accesses and the reported length in the report cycle that follows the last write. Because of this, every command is checked by comparing the whole frame against a model and checking the report.

// File: rtl/raster_pkg.sv
// Shared types for the raster engine: window codes, decoded operations and
// sequencer states. Assumes a 32-bit host data path.
package raster_pkg;

    localparam int WORD_W    = 32;
    localparam int RUN_W     = 5;
    localparam int LEN_W     = RUN_W + 1;
    localparam int SRC_W     = 24;
    localparam logic [SRC_W-1:0] FILL_KEY = '1;

    typedef enum logic [1:0] {
        WIN_CTRL = 2'b00,
        WIN_STIP = 2'b01,
        WIN_BLIT = 2'b10,
        WIN_NONE = 2'b11
    } win_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_COLOUR,
        OP_STIP,
        OP_FILL,
        OP_COPY
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STIP,
        S_FILL,
        S_RD,
        S_WR,
        S_DONE
    } seq_e;

endpackage

// File: rtl/raster_cmd_decode.sv
// Turns one accepted bus access into an engine operation.
// Assumes: fire is high only when the request is accepted. Only full-word,
// word-aligned writes produce an operation; everything else decodes to OP_NONE.
module raster_cmd_decode
    import raster_pkg::*;
#(
    parameter int PIX_AW = 12,
    localparam int BUS_AW = PIX_AW + 5
) (
    input  logic              fire,
    input  logic              we,
    input  logic [3:0]        be,
    input  logic [BUS_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output op_e               op,
    output logic [PIX_AW-1:0] dest,
    output logic [PIX_AW-1:0] src,
    output logic [LEN_W-1:0]  run_len
);

    win_e             win;
    logic             full_word;
    logic [SRC_W-1:0] src_field;
    logic             unused_bits;

    assign win       = win_e'(addr[BUS_AW-1 -: 2]);
    assign full_word = fire && we && (be == 4'hF) && (addr[1:0] == 2'b00);
    assign src_field = wdata[SRC_W-1:0];
    assign dest      = addr[PIX_AW+2:3];
    assign src       = src_field[PIX_AW-1:0];
    assign run_len   = {1'b0, wdata[SRC_W +: RUN_W]} + LEN_W'(1);
    assign unused_bits = ^{addr[2], wdata[WORD_W-1:SRC_W+RUN_W]};

    // Classify the access by window and source key.
    always_comb begin
        op = OP_NONE;
        if (full_word) begin
            unique case (win)
                WIN_CTRL: op = OP_COLOUR;
                WIN_STIP: op = OP_STIP;
                WIN_BLIT: op = (src_field == FILL_KEY) ? OP_FILL : OP_COPY;
                default:  op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/raster_colour_reg.sv
// Foreground colour register. Loads the low data byte on a colour operation.
// Assumes: stays stable while the sequencer is busy, because no access is
// accepted in that time.
module raster_colour_reg
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_e        op,
    input  logic [7:0] din,
    output logic [7:0] colour
);

    // Hold the colour; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            colour <= 8'h00;
        else if (op == OP_COLOUR)
            colour <= din;
    end

endmodule

// File: rtl/raster_sequencer.sv
// Runs one stipple, fill or copy command against a single-port byte memory.
// It makes at most one access per clock, and a copy does a read then a
// write for each pixel. A report cycle follows the last access.
// Assumes: the memory returns read data one cycle after the read, and start
// operations are presented only while idle.
module raster_sequencer
    import raster_pkg::*;
#(
    parameter int PIX_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [PIX_AW-1:0] dest,
    input  logic [PIX_AW-1:0] src,
    input  logic [LEN_W-1:0]  run_len,
    input  logic [WORD_W-1:0] pattern,
    input  logic [7:0]        colour,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              dirty_valid,
    output logic [PIX_AW-1:0] dirty_base,
    output logic [LEN_W-1:0]  dirty_len
);

    seq_e              st_q;
    logic [PIX_AW-1:0] base_q;
    logic [PIX_AW-1:0] src_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [WORD_W-1:0] pat_q;
    logic              last;

    assign last = (idx_q == len_q - LEN_W'(1));

    // Advance the command state, the pixel index and the pattern shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            base_q <= '0;
            src_q  <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            pat_q  <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    idx_q <= '0;
                    if (op == OP_STIP) begin
                        st_q   <= S_STIP;
                        base_q <= dest;
                        pat_q  <= pattern;
                        len_q  <= LEN_W'(WORD_W);
                    end else if (op == OP_FILL) begin
                        st_q   <= S_FILL;
                        base_q <= dest;
                        len_q  <= run_len;
                    end else if (op == OP_COPY) begin
                        st_q   <= S_RD;
                        base_q <= dest;
                        src_q  <= src;
                        len_q  <= run_len;
                    end
                end
                S_STIP: begin
                    pat_q <= pat_q << 1;
                    idx_q <= idx_q + LEN_W'(1);
                    if (last) st_q <= S_DONE;
                end
                S_FILL: begin
                    idx_q <= idx_q + LEN_W'(1);
                    if (last) st_q <= S_DONE;
                end
                S_RD: st_q <= S_WR;
                S_WR: begin
                    idx_q <= idx_q + LEN_W'(1);
                    st_q  <= last ? S_DONE : S_RD;
                end
                S_DONE:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port for the current state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q + PIX_AW'(idx_q);
        mem_wdata = colour;
        unique case (st_q)
            S_STIP: begin
                mem_en = pat_q[WORD_W-1];
                mem_we = pat_q[WORD_W-1];
            end
            S_FILL: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            S_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_q + PIX_AW'(idx_q);
            end
            S_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    assign busy        = (st_q != S_IDLE);
    assign dirty_valid = (st_q == S_DONE);
    assign dirty_base  = base_q;
    assign dirty_len   = len_q;

endmodule

// File: rtl/raster_engine.sv
// Top of the raster engine. Accepts one bus access per cycle while idle,
// decodes it, holds the colour and runs the drawing sequencer. Reads are
// acknowledged one cycle later with zero data.
// Assumes: PIX_AW <= 20, so that the source field covers the frame.
module raster_engine
    import raster_pkg::*;
#(
    parameter int PIX_AW = 12,
    localparam int BUS_AW = PIX_AW + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [3:0]        req_be,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              dirty_valid,
    output logic [PIX_AW-1:0] dirty_base,
    output logic [5:0]        dirty_len
);

    logic              fire;
    op_e               op;
    logic [PIX_AW-1:0] dest;
    logic [PIX_AW-1:0] src;
    logic [LEN_W-1:0]  run_len;
    logic [7:0]        colour;

    assign req_ready = !busy;
    assign fire      = req_valid && req_ready;
    assign rd_data   = '0;

    // Acknowledge an accepted read in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= fire && !req_we;
    end

    raster_cmd_decode #(.PIX_AW(PIX_AW)) u_dec (
        .fire    (fire),
        .we      (req_we),
        .be      (req_be),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .op      (op),
        .dest    (dest),
        .src     (src),
        .run_len (run_len)
    );

    raster_colour_reg u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .din    (req_wdata[7:0]),
        .colour (colour)
    );

    raster_sequencer #(.PIX_AW(PIX_AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .dest        (dest),
        .src         (src),
        .run_len     (run_len),
        .pattern     (req_wdata),
        .colour      (colour),
        .busy        (busy),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .dirty_valid (dirty_valid),
        .dirty_base  (dirty_base),
        .dirty_len   (dirty_len)
    );

endmodule

// File: rtl/raster_engine_chk.sv
// Port-level protocol checks for the raster engine, bound to every instance.
module raster_engine_chk #(
    parameter int PIX_AW = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_we,
    input logic        busy,
    input logic        mem_en,
    input logic        mem_we,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        dirty_valid,
    input logic [5:0]  dirty_len
);

    AST_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy); // R9
    AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R9
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we)); // R5
    AST_REPORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |=> !busy); // R3
    AST_REPORT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> !mem_en); // R6
    AST_REPORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (dirty_len != 6'd0 && dirty_len <= 6'd32)); // R6
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data == 32'd0)); // R7
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_we)); // R9

endmodule

bind raster_engine raster_engine_chk #(.PIX_AW(PIX_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .busy        (busy),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .dirty_valid (dirty_valid),
    .dirty_len   (dirty_len)
);

// File: tb/raster_engine_test.sv
// Self-checking bench: behavioural frame memory plus a reference frame.
module raster_engine_test;

    localparam int PIX_AW = 12;
    localparam int BUS_AW = PIX_AW + 5;
    localparam int NPIX   = 1 << PIX_AW;
    localparam int NVEC   = 12;

    // {window[1:0], dest[11:0], data[31:0]}
    localparam logic [45:0] VEC [NVEC] = '{
        {2'b00, 12'd0,    32'h0000_003C},
        {2'b01, 12'd100,  32'hA5F0_0F81},
        {2'b01, 12'd200,  32'h0000_0000},
        {2'b01, 12'd300,  32'hFFFF_FFFF},
        {2'b00, 12'd0,    32'hABCD_12C7},
        {2'b10, 12'd500,  32'h00FF_FFFF},
        {2'b10, 12'd600,  32'hFFFF_FFFF},
        {2'b10, 12'd1000, 32'h0600_0028},
        {2'b10, 12'd701,  32'h0700_02BC},
        {2'b10, 12'd800,  32'h1F00_0384},
        {2'b01, 12'd4080, 32'hFFFF_0001},
        {2'b10, 12'd4090, 32'h09FF_FFFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [3:0]        req_be = 4'h0;
    logic [BUS_AW-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              busy;
    logic              mem_en;
    logic              mem_we;
    logic [PIX_AW-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;
    logic              dirty_valid;
    logic [PIX_AW-1:0] dirty_base;
    logic [5:0]        dirty_len;

    logic [7:0] fb      [NPIX];
    logic [7:0] ref_fb  [NPIX];
    logic [7:0] ref_col;
    int errors = 0;
    int checks = 0;
    int dirty_cnt = 0;
    int acc_cnt = 0;
    int got_base = 0;
    int got_len = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raster_engine #(.PIX_AW(PIX_AW)) uut (.*);

    // Behavioural single-port frame memory, read latency one.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) fb[mem_addr] <= mem_wdata;
            else        mem_rdata    <= fb[mem_addr];
        end
    end

    // Record reports and memory accesses.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_en) acc_cnt++;
            if (dirty_valid) begin
                dirty_cnt++;
                got_base = int'(dirty_base);
                got_len  = int'(dirty_len);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic bus_op(input bit we, input logic [3:0] be,
                          input logic [BUS_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame_cmp(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < NPIX; i++)
            if (fb[i] !== ref_fb[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, int'(fb[first]), int'(ref_fb[first]));
    endtask

    // Apply a command to the reference frame; return the expected report.
    task automatic model(input logic [1:0] win, input logic [11:0] dst,
                         input logic [31:0] d, output int eb, output int el);
        eb = int'(dst); el = 0;
        if (win == 2'b00) ref_col = d[7:0];
        else if (win == 2'b01) begin
            el = 32;
            for (int i = 0; i < 32; i++)
                if (d[31-i]) ref_fb[(int'(dst) + i) % NPIX] = ref_col;
        end else if (win == 2'b10) begin
            el = int'(d[28:24]) + 1;
            for (int i = 0; i < el; i++) begin
                if (d[23:0] == 24'hFFFFFF) ref_fb[(int'(dst) + i) % NPIX] = ref_col;
                else ref_fb[(int'(dst) + i) % NPIX] = ref_fb[(int'(d[11:0]) + i) % NPIX];
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int eb, el, d0, a0;
        for (int i = 0; i < NPIX; i++) begin
            fb[i] = 8'(i) ^ 8'h5A;
            ref_fb[i] = fb[i];
        end
        ref_col = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && req_ready, "R11 idle after reset", int'(busy), 0);
        chk(!mem_en && !dirty_valid && !rd_valid, "R11 quiet after reset", int'(mem_en), 0);

        // R11 colour is zero after reset; R9 fill length 4 takes 4 accesses
        acc_cnt = 0;
        bus_op(1'b1, 4'hF, {2'b10, 12'd50, 3'b000}, 32'h03FF_FFFF);
        model(2'b10, 12'd50, 32'h03FF_FFFF, eb, el);
        wait_idle();
        frame_cmp("R11 reset colour fill");
        chk(acc_cnt == 4, "R9 fill accesses", acc_cnt, 4);

        // Table walk: R1 R2 R3 R4 R5 R6 R10 R12
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0]  w;
            logic [11:0] dst;
            logic [31:0] dat;
            {w, dst, dat} = VEC[k];
            d0 = dirty_cnt;
            model(w, dst, dat, eb, el);
            bus_op(1'b1, 4'hF, {w, dst, (k % 2 == 1) ? 3'b100 : 3'b000}, dat);
            wait_idle();
            frame_cmp($sformatf("R1 R2 R4 R5 R10 R12 vector %0d frame", k));
            if (w != 2'b00) begin
                chk(dirty_cnt == d0 + 1, "R3 R6 one report", dirty_cnt - d0, 1);
                chk(got_base == eb, "R3 R6 report base", got_base, eb);
                chk(got_len == el, "R3 R6 report length", got_len, el);
            end
        end

        // R9 back-pressure while a stipple runs
        bus_op(1'b1, 4'hF, {2'b01, 12'd2000, 3'b000}, 32'h8000_0001);
        model(2'b01, 12'd2000, 32'h8000_0001, eb, el);
        chk(busy && !req_ready, "R9 ready low while busy", int'(req_ready), 0);
        wait_idle();
        frame_cmp("R2 sparse stipple");

        // R5 R9 copy of length 5 takes 10 accesses
        acc_cnt = 0;
        bus_op(1'b1, 4'hF, {2'b10, 12'd3000, 3'b000}, 32'h0400_0064);
        model(2'b10, 12'd3000, 32'h0400_0064, eb, el);
        wait_idle();
        chk(acc_cnt == 10, "R5 R9 copy accesses", acc_cnt, 10);
        frame_cmp("R5 copy frame");

        // R7 read returns zero, no side effect
        d0 = dirty_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_be = 4'hF;
        req_addr = {2'b10, 12'd10, 3'b000}; req_wdata = 32'h00FF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_valid && rd_data == 32'd0, "R7 read response", int'(rd_data), 0);
        chk(!busy && dirty_cnt == d0, "R7 read no command", int'(busy), 0);
        @(negedge clk);
        frame_cmp("R7 read leaves frame");

        // R8 ignored writes: partial enables, misaligned, unused window
        a0 = acc_cnt;
        bus_op(1'b1, 4'h7, {2'b10, 12'd10, 3'b000}, 32'h1FFF_FFFF);
        chk(!busy, "R8 partial enables no busy", int'(busy), 0);
        bus_op(1'b1, 4'hF, {2'b10, 12'd10, 3'b010}, 32'h1FFF_FFFF);
        chk(!busy, "R8 misaligned no busy", int'(busy), 0);
        bus_op(1'b1, 4'hF, {2'b11, 12'd10, 3'b000}, 32'h1FFF_FFFF);
        bus_op(1'b1, 4'h1, {2'b00, 12'd0, 3'b000}, 32'h0000_0011);
        repeat (3) @(negedge clk);
        chk(dirty_cnt == d0 && acc_cnt == a0, "R8 no report or access", dirty_cnt - d0, 0);
        frame_cmp("R8 frame unchanged");
        // colour must still be the last one loaded
        bus_op(1'b1, 4'hF, {2'b10, 12'd20, 3'b000}, 32'h01FF_FFFF);
        model(2'b10, 12'd20, 32'h01FF_FFFF, eb, el);
        wait_idle();
        frame_cmp("R8 R10 colour kept");

        finish_run();
    end

endmodule